// File: doc/BRIEF.md
# Architectural State and Control-Flow Unit

This unit holds the programmer-visible state of a compact 32-bit RISC core: fifteen writable 32-bit general registers, a register 0 that always reads zero, an 8-bit status byte and a program counter whose low 24 bits are live. Each cycle it may accept one decoded instruction. The instruction arrives as an operation class, register indices, an 8-bit immediate, a status-bit selector and a byte length. Outside logic supplies ALU results and the zero, carry and negative flags. This unit stores them, serves two combinational read ports and moves the program counter.

The unit carries out bit set and bit clear itself. When the target index is register 0, the immediate becomes an 8-bit mask over the status byte. The unit also resolves conditional branches on any single status bit, and it handles jump-and-link. A jump-and-link whose source is register 0 only records the return address and does not redirect the program counter. A read that hits the register being written in the same cycle sees the new value.

Top module: `archstate_unit`

## Requirements
- R1: The active-low asynchronous reset clears every register, the status byte and the program counter to zero.
- R2: Register index 0 reads as zero on both read ports. Any write aimed at it is dropped.
- R3: With `valid_i`=1, `op_i`=0 (sequential) and `res_we_i`=1, `res_data_i` is stored into register `rd_i` (1..15) on the clock edge. `ra_data_o` and `rb_data_o` return the registers indexed by `ra_i` and `rb_i`.
- R4: When a read index equals the index being written in the same cycle (nonzero), that read port returns the value being written.
- R5: Status bit 0 is Z, bit 1 is C, bit 2 is N and bits 4..7 are user flags. `flag_we_i` on a sequential op loads `flag_zcn_i` bits {N,C,Z} into bits 2..0. Bit 3 always reads 0 and cannot be set, and a branch on it behaves as if it were 0.
- R6: `op_i`=1 (set) and `op_i`=2 (clear) with `rd_i`≠0 set or clear bit `imm_i[4:0]` of that register.
- R7: With `rd_i`=0, set ORs `imm_i` into the status byte and clear removes the bits of `imm_i` from it.
- R8: The following-instruction address is (PC + `len_i`) mod 2^24. Sequential, set, clear and the unused op codes 6 and 7 load it into the PC. `pc_o[31:24]` is always 0.
- R9: `op_i`=3 branches when status bit `flag_sel_i` is 0, and `op_i`=4 branches when it is 1. The target is following address + 2 × sign-extended `imm_i`, mod 2^24. An untaken branch takes the following address.
- R10: `op_i`=5 (jump-and-link) writes {8'h0, following address} into `rd_i` and loads the PC from the low 24 bits of register `ra_i`, read before this cycle's write. With `ra_i`=0 the PC takes the following address instead.
- R11: With `valid_i`=0, no register, status bit or PC changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Decoded instruction present this cycle |
| op_i | input | 3 | Operation class: 0 seq, 1 set, 2 clear, 3 branch-if-0, 4 branch-if-1, 5 jump-and-link |
| len_i | input | 3 | Instruction length in bytes |
| rd_i | input | 4 | Destination / bit-op target index |
| ra_i | input | 4 | Read port A index, jump source |
| rb_i | input | 4 | Read port B index |
| imm_i | input | 8 | Bit index, status mask or branch displacement |
| flag_sel_i | input | 3 | Status bit tested by a branch |
| res_we_i | input | 1 | Store external result on a sequential op |
| res_data_i | input | 32 | External result |
| flag_we_i | input | 1 | Load Z/C/N on a sequential op |
| flag_zcn_i | input | 3 | New {N,C,Z} |
| ra_data_o | output | 32 | Read port A data |
| rb_data_o | output | 32 | Read port B data |
| pc_o | output | 32 | Program counter |
| status_o | output | 8 | Status byte |

## Verification
The bench goes after the places where this unit departs from an ordinary register file. Bit operations on register 0 must reach the status byte. If they instead reached the zero register, the status byte would not move. A mask that includes bit 3 must leave that bit at zero, and a design that stored it would also make branches on bit 3 taken. Jump-and-link is tried with a zero source, with a zero destination, and with source equal to destination. Getting the ordering wrong would jump to the freshly written return address. Backward branches and a sequential step from near the top of the 24-bit space check the modulo wrap, and a same-cycle write and read check the forwarding path. Each of these errors shows up at the PC, status or read-port outputs.

// File: rtl/archstate_pkg.sv
package archstate_pkg;
  typedef enum logic [2:0] {
    OP_SEQ  = 3'd0,
    OP_BSET = 3'd1,
    OP_BCLR = 3'd2,
    OP_BRC  = 3'd3,
    OP_BRS  = 3'd4,
    OP_JAL  = 3'd5
  } op_e;

  localparam int unsigned SR_W   = 8;
  localparam int unsigned SR_Z   = 0;
  localparam int unsigned SR_C   = 1;
  localparam int unsigned SR_N   = 2;
  localparam int unsigned SR_RSV = 3;
endpackage

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [IW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [IW-1:0]   ra_idx_i,
  input  logic [IW-1:0]   rb_idx_i,
  input  logic [IW-1:0]   rx_idx_i,
  output logic [XLEN-1:0] ra_raw_o,
  output logic [XLEN-1:0] rx_raw_o,
  output logic [XLEN-1:0] ra_byp_o,
  output logic [XLEN-1:0] rb_byp_o
);
  logic [XLEN-1:0] q [NREG];
  logic            wr_live;

  assign wr_live = we_i && (waddr_i != '0);

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == 0) begin : g_zero
        assign q[g] = '0;
      end else begin : g_live
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)                              q[g] <= '0;
          else if (wr_live && waddr_i == IW'(g))    q[g] <= wdata_i;
        end
      end
    end
  endgenerate

  assign ra_raw_o = q[ra_idx_i];
  assign rx_raw_o = q[rx_idx_i];

  // write-first forwarding on the external read ports
  assign ra_byp_o = (wr_live && waddr_i == ra_idx_i) ? wdata_i : q[ra_idx_i];
  assign rb_byp_o = (wr_live && waddr_i == rb_idx_i) ? wdata_i : q[rb_idx_i];
endmodule

// File: rtl/status_unit.sv
module status_unit
  import archstate_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            zcn_we_i,
  input  logic [2:0]      zcn_i,
  input  logic            set_we_i,
  input  logic            clr_we_i,
  input  logic [SR_W-1:0] mask_i,
  output logic [SR_W-1:0] status_o
);
  localparam logic [SR_W-1:0] LIVE_MASK = ~(SR_W'(1) << SR_RSV);

  logic [SR_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (zcn_we_i) begin
      sr_d[SR_Z] = zcn_i[0];
      sr_d[SR_C] = zcn_i[1];
      sr_d[SR_N] = zcn_i[2];
    end
    if (set_we_i) sr_d = sr_d | mask_i;
    if (clr_we_i) sr_d = sr_d & ~mask_i;
    sr_d = sr_d & LIVE_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign status_o = sr_q;
endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import archstate_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  op_e             op_i,
  input  logic [2:0]      len_i,
  input  logic [7:0]      disp_i,
  input  logic [2:0]      sel_i,
  input  logic [SR_W-1:0] status_i,
  input  logic [XLEN-1:0] ra_raw_i,
  input  logic            ra_zero_i,
  output logic [XLEN-1:0] pc_o,
  output logic [AW-1:0]   seq_o
);
  logic [AW-1:0] pc_q, pc_d, seq, br_off, br_tgt;
  logic          bit_v, taken;

  assign seq    = pc_q + AW'(len_i);
  assign br_off = {{(AW-9){disp_i[7]}}, disp_i, 1'b0};
  assign br_tgt = seq + br_off;
  assign bit_v  = status_i[sel_i];

  always_comb begin
    taken = 1'b0;
    pc_d  = seq;
    unique case (op_i)
      OP_BRC: taken = !bit_v;
      OP_BRS: taken = bit_v;
      default: taken = 1'b0;
    endcase
    if (taken) pc_d = br_tgt;
    if (op_i == OP_JAL && !ra_zero_i) pc_d = ra_raw_i[AW-1:0];
    if (!valid_i) pc_d = pc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o  = XLEN'(pc_q);
  assign seq_o = seq;
endmodule

// File: rtl/archstate_unit.sv
module archstate_unit
  import archstate_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 16,
  parameter int unsigned AW   = 24,
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned KW  = $clog2(XLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic [2:0]      len_i,
  input  logic [IW-1:0]   rd_i,
  input  logic [IW-1:0]   ra_i,
  input  logic [IW-1:0]   rb_i,
  input  logic [7:0]      imm_i,
  input  logic [2:0]      flag_sel_i,
  input  logic            res_we_i,
  input  logic [XLEN-1:0] res_data_i,
  input  logic            flag_we_i,
  input  logic [2:0]      flag_zcn_i,
  output logic [XLEN-1:0] ra_data_o,
  output logic [XLEN-1:0] rb_data_o,
  output logic [XLEN-1:0] pc_o,
  output logic [SR_W-1:0] status_o
);
  op_e             op;
  logic            rx_zero, ra_zero;
  logic            gpr_we;
  logic [XLEN-1:0] gpr_wdata, ra_raw, rx_raw, bit_mask;
  logic [AW-1:0]   seq_addr;
  logic            sr_set, sr_clr, sr_zcn;

  assign op       = op_e'(op_i);
  assign rx_zero  = (rd_i == '0);
  assign ra_zero  = (ra_i == '0);
  assign bit_mask = XLEN'(1) << imm_i[KW-1:0];

  always_comb begin
    gpr_we    = 1'b0;
    gpr_wdata = res_data_i;
    unique case (op)
      OP_SEQ:  begin gpr_we = res_we_i;  gpr_wdata = res_data_i;          end
      OP_BSET: begin gpr_we = !rx_zero;  gpr_wdata = rx_raw | bit_mask;   end
      OP_BCLR: begin gpr_we = !rx_zero;  gpr_wdata = rx_raw & ~bit_mask;  end
      OP_JAL:  begin gpr_we = 1'b1;      gpr_wdata = XLEN'(seq_addr);     end
      default: begin gpr_we = 1'b0;      gpr_wdata = res_data_i;          end
    endcase
    if (!valid_i) gpr_we = 1'b0;
  end

  assign sr_zcn = valid_i && op == OP_SEQ  && flag_we_i;
  assign sr_set = valid_i && op == OP_BSET && rx_zero;
  assign sr_clr = valid_i && op == OP_BCLR && rx_zero;

  gpr_bank #(.XLEN(XLEN), .NREG(NREG)) u_gpr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (gpr_we),
    .waddr_i  (rd_i),
    .wdata_i  (gpr_wdata),
    .ra_idx_i (ra_i),
    .rb_idx_i (rb_i),
    .rx_idx_i (rd_i),
    .ra_raw_o (ra_raw),
    .rx_raw_o (rx_raw),
    .ra_byp_o (ra_data_o),
    .rb_byp_o (rb_data_o)
  );

  status_unit u_sr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .zcn_we_i (sr_zcn),
    .zcn_i    (flag_zcn_i),
    .set_we_i (sr_set),
    .clr_we_i (sr_clr),
    .mask_i   (imm_i),
    .status_o (status_o)
  );

  pc_unit #(.XLEN(XLEN), .AW(AW)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .op_i      (op),
    .len_i     (len_i),
    .disp_i    (imm_i),
    .sel_i     (flag_sel_i),
    .status_i  (status_o),
    .ra_raw_i  (ra_raw),
    .ra_zero_i (ra_zero),
    .pc_o      (pc_o),
    .seq_o     (seq_addr)
  );
endmodule

// File: rtl/archstate_unit_chk.sv
module archstate_unit_chk
  import archstate_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [2:0]  op_i,
  input logic [2:0]  len_i,
  input logic [3:0]  rd_i,
  input logic [3:0]  ra_i,
  input logic [3:0]  rb_i,
  input logic [2:0]  flag_sel_i,
  input logic        res_we_i,
  input logic [31:0] res_data_i,
  input logic [31:0] ra_data_o,
  input logic [31:0] rb_data_o,
  input logic [31:0] pc_o,
  input logic [7:0]  status_o
);
  // R2
  r0_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_i == 4'd0 |-> ra_data_o == 32'd0) and (rb_i == 4'd0 |-> rb_data_o == 32'd0));

  // R4
  fwd_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SEQ && res_we_i && rd_i != 4'd0 && ra_i == rd_i)
      |-> ra_data_o == res_data_i);

  // R5
  sr_rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[SR_RSV] == 1'b0);

  // R8
  pc_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[31:AW] == '0);

  // R8
  seq_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SEQ) |=> pc_o[AW-1:0] == $past(pc_o[AW-1:0] + AW'(len_i)));

  // R9
  br_rsv_never_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_BRS && flag_sel_i == 3'd3)
      |=> pc_o[AW-1:0] == $past(pc_o[AW-1:0] + AW'(len_i)));

  // R10
  jal_no_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_JAL && ra_i == 4'd0)
      |=> pc_o[AW-1:0] == $past(pc_o[AW-1:0] + AW'(len_i)));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pc_o) && $stable(status_o));
endmodule

bind archstate_unit archstate_unit_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .len_i      (len_i),
  .rd_i       (rd_i),
  .ra_i       (ra_i),
  .rb_i       (rb_i),
  .flag_sel_i (flag_sel_i),
  .res_we_i   (res_we_i),
  .res_data_i (res_data_i),
  .ra_data_o  (ra_data_o),
  .rb_data_o  (rb_data_o),
  .pc_o       (pc_o),
  .status_o   (status_o)
);

// File: tb/archstate_unit_tb_top.sv
module archstate_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0, len_i = '0, flag_sel_i = '0, flag_zcn_i = '0;
  logic [3:0]  rd_i = '0, ra_i = '0, rb_i = '0;
  logic [7:0]  imm_i = '0;
  logic        res_we_i = 1'b0, flag_we_i = 1'b0;
  logic [31:0] res_data_i = '0;
  logic [31:0] ra_data_o, rb_data_o, pc_o;
  logic [7:0]  status_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  archstate_unit dut_i (.*);

  typedef struct {
    string       tag;
    logic [31:0] pc;
    logic [7:0]  sr;
    logic [31:0] a;
    logic [31:0] b;
  } item_t;

  item_t       sbq[$];
  int          checks = 0;
  int          fails  = 0;
  logic [31:0] m_r [16];
  logic [7:0]  m_sr;
  logic [23:0] m_pc;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compare post-edge state against queued expectations
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check(it.tag, "pc", pc_o, it.pc);
        check(it.tag, "status", {24'd0, status_o}, {24'd0, it.sr});
        check(it.tag, "port_a", ra_data_o, it.a);
        check(it.tag, "port_b", rb_data_o, it.b);
      end
    end
  end

  // driver: apply one instruction, update the reference model, queue expectation
  task automatic issue(input bit v, input logic [2:0] op, input logic [2:0] len,
                       input logic [3:0] rd, input logic [3:0] ra, input logic [3:0] rb,
                       input logic [7:0] imm, input logic [2:0] sel,
                       input bit we, input logic [31:0] data, input bit fwe, input logic [2:0] zcn,
                       input string tag, input bit byp);
    item_t       it;
    logic [23:0] seq;
    logic [31:0] olda;
    bit          take;
    @(negedge clk_i);
    valid_i = v; op_i = op; len_i = len; rd_i = rd; ra_i = ra; rb_i = rb;
    imm_i = imm; flag_sel_i = sel; res_we_i = we; res_data_i = data;
    flag_we_i = fwe; flag_zcn_i = zcn;
    if (v) begin
      seq  = m_pc + 24'(len);
      olda = m_r[ra];
      take = 1'b0;
      case (op)
        3'd0: begin
          if (we && rd != 0) m_r[rd] = data;
          if (fwe) m_sr[2:0] = zcn;
        end
        3'd1: if (rd == 0) m_sr = m_sr | imm; else m_r[rd] = m_r[rd] | (32'd1 << imm[4:0]);
        3'd2: if (rd == 0) m_sr = m_sr & ~imm; else m_r[rd] = m_r[rd] & ~(32'd1 << imm[4:0]);
        3'd3: take = !m_sr[sel];
        3'd4: take = m_sr[sel];
        3'd5: if (rd != 0) m_r[rd] = {8'd0, seq};
        default: ;
      endcase
      m_sr[3] = 1'b0;
      m_pc = seq;
      if (take) m_pc = seq + {{15{imm[7]}}, imm, 1'b0};
      if (op == 3'd5 && ra != 0) m_pc = olda[23:0];
    end
    it.tag = tag; it.pc = {8'd0, m_pc}; it.sr = m_sr; it.a = m_r[ra]; it.b = m_r[rb];
    sbq.push_back(it);
    if (byp) begin
      #1;
      check(tag, "forward", ra_data_o, data);
    end
    @(posedge clk_i);
    #1 valid_i = 1'b0;
  endtask

  task automatic peek(input logic [3:0] ra, input logic [3:0] rb, input string tag);
    issue(0, 3'd0, 3'd2, 4'd0, ra, rb, 8'd0, 3'd0, 0, 32'd0, 0, 3'd0, tag, 0);
  endtask

  task automatic wr(input logic [3:0] rd, input logic [31:0] d, input logic [2:0] len, input string tag);
    issue(1, 3'd0, len, rd, rd, 4'd0, 8'd0, 3'd0, 1, d, 0, 3'd0, tag, 0);
  endtask

  task automatic op8(input logic [2:0] op, input logic [3:0] rd, input logic [3:0] ra,
                     input logic [7:0] imm, input logic [2:0] sel, input logic [2:0] len, input string tag);
    issue(1, op, len, rd, ra, rd, imm, sel, 0, 32'd0, 0, 3'd0, tag, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog all actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_r[i] = '0;
    m_sr = '0; m_pc = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    peek(4'd1, 4'd15, "R1");
    // R3 write and read back on both ports; R2 on port B
    wr(4'd1, 32'hDEADBEEF, 3'd2, "R3");
    peek(4'd1, 4'd0, "R3");
    // R2 write to register 0 dropped
    wr(4'd0, 32'h00001234, 3'd4, "R2");
    peek(4'd0, 4'd1, "R2");
    // R8 six-byte step, R3 port B
    wr(4'd15, 32'hA5A5_5A5A, 3'd6, "R8");
    peek(4'd15, 4'd1, "R3");
    // R4 same-cycle forward
    issue(1, 3'd0, 3'd2, 4'd5, 4'd5, 4'd5, 8'd0, 3'd0, 1, 32'h0BADF00D, 0, 3'd0, "R4", 1);
    // R5 flag load: {N,C,Z}=101
    issue(1, 3'd0, 3'd2, 4'd0, 4'd0, 4'd0, 8'd0, 3'd0, 0, 32'd0, 1, 3'b101, "R5", 0);
    // R7 status mask set/clear; R5 bit 3 stays 0
    op8(3'd1, 4'd0, 4'd0, 8'hFF, 3'd0, 3'd2, "R7");
    op8(3'd2, 4'd0, 4'd0, 8'h0A, 3'd0, 3'd2, "R7");
    op8(3'd1, 4'd0, 4'd0, 8'h08, 3'd0, 3'd2, "R5");
    // R6 register bit set/clear, index taken mod 32
    op8(3'd1, 4'd2, 4'd2, 8'd31, 3'd0, 3'd2, "R6");
    op8(3'd1, 4'd2, 4'd2, 8'h20, 3'd0, 3'd2, "R6");
    op8(3'd2, 4'd1, 4'd1, 8'd0, 3'd0, 3'd4, "R6");
    peek(4'd2, 4'd1, "R6");
    // R9 branches: status now F5 (Z=1,C=0,N=1,F4..F7=1)
    op8(3'd4, 4'd0, 4'd0, 8'd5, 3'd0, 3'd2, "R9");
    op8(3'd3, 4'd0, 4'd0, 8'd5, 3'd0, 3'd2, "R9");
    op8(3'd3, 4'd0, 4'd0, 8'h10, 3'd1, 3'd2, "R9");
    op8(3'd4, 4'd0, 4'd0, 8'h40, 3'd3, 3'd2, "R9");
    op8(3'd4, 4'd0, 4'd0, 8'h80, 3'd7, 3'd2, "R9");
    op8(3'd4, 4'd0, 4'd0, 8'h80, 3'd6, 3'd2, "R9");
    // R10 jump-and-link forms
    wr(4'd3, 32'h12FF_FFFE, 3'd2, "R3");
    op8(3'd5, 4'd7, 4'd3, 8'd0, 3'd0, 3'd2, "R10");
    peek(4'd7, 4'd0, "R10");
    wr(4'd4, 32'h0000_0000, 3'd4, "R8");
    op8(3'd5, 4'd0, 4'd1, 8'd0, 3'd0, 3'd2, "R10");
    peek(4'd0, 4'd7, "R10");
    op8(3'd5, 4'd9, 4'd0, 8'd0, 3'd0, 3'd4, "R10");
    peek(4'd9, 4'd3, "R10");
    op8(3'd5, 4'd3, 4'd3, 8'd0, 3'd0, 3'd2, "R10");
    peek(4'd3, 4'd9, "R10");
    // R11 idle cycles with live-looking fields
    issue(0, 3'd1, 3'd2, 4'd0, 4'd0, 4'd0, 8'hFF, 3'd0, 0, 32'd0, 0, 3'd0, "R11", 0);
    issue(0, 3'd0, 3'd2, 4'd4, 4'd4, 4'd4, 8'd0, 3'd0, 1, 32'hFFFF_FFFF, 1, 3'b000, "R11", 0);
    issue(0, 3'd5, 3'd2, 4'd6, 4'd1, 4'd6, 8'd0, 3'd0, 0, 32'd0, 0, 3'd0, "R11", 0);
    peek(4'd4, 4'd6, "R11");
    // R8 unused op code only advances
    op8(3'd7, 4'd8, 4'd8, 8'hFF, 3'd0, 3'd6, "R8");
    repeat (3) @(posedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule